// File: doc/BRIEF.md
# Tower-Field AES Byte Substitution

This block performs the AES forward byte substitution without any lookup table. The input byte is first moved by a linear basis change into a nested field representation: GF(2^2), then GF(2^4) over it, then GF(2^8) over that. The multiplicative inverse is formed there using only two-bit multiply and inverse formulas. The result is moved back to the polynomial basis defined by x^8+x^4+x^3+x+1, and the AES affine transform is applied to it.

Three cut points separate the arithmetic into levels: after the basis change and 4-bit norm, after the 4-bit inversion, and after the final multiply, back-map and affine step. The parameter `STAGES` (0 to 3) sets how many of these cut points, counted from the input side, get a register. A valid flag travels through the same registers. With `STAGES` = 0 the block is purely combinational. The basis-change matrices are derived at elaboration from the chosen field constants and are not typed in by hand.

Top module: `aes_sbox_tower`

## Requirements
- R1: When an input byte is accepted, `dout` carries its AES forward substitution value. Examples: 0x53 gives 0xED, 0x01 gives 0x7C and 0xFF gives 0x16.
- R2: The forward basis map and the backward basis map are exact inverses of each other for every byte.
- R3: For every nonzero tower-field element, the computed inverse multiplied by the element equals one.
- R4: An input of 0x00 is treated as having inverse 0, so the output is 0x63.
- R5: `dout_vld` repeats `din_vld` exactly `STAGES` clock cycles later. With `STAGES` = 0, `dout_vld` equals `din_vld` in the same cycle.
- R6: A new byte can be accepted on every cycle, and each result appears on the cycle its valid flag is high, with no unknown bits.
- R7: While `rst` is high, and on the first sampling after it, `dout_vld` is low and any in-flight bytes are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the valid pipeline |
| din_vld | input | 1 | Input byte is present |
| din | input | 8 | Byte to substitute, polynomial basis |
| dout_vld | output | 1 | Output byte is present |
| dout | output | 8 | Substituted byte |

## Verification
Each result is due exactly `STAGES` rising edges after its input is driven. The bench drives on falling edges and keeps a queue that is pre-filled with `STAGES` empty entries after every reset. On each falling edge it pops one expected entry and compares it with the outputs of the three-stage instance. A second instance built with zero stages is compared 1 ns after each drive, within the same cycle. The reference values come from an exhaustive inverse search in the polynomial basis, computed once before the run.

// File: rtl/aes_sbox_tower.sv
module aes_sbox_tower #(
  parameter int STAGES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din_vld,
  input  logic [7:0] din,
  output logic       dout_vld,
  output logic [7:0] dout
);
  localparam int NS = (STAGES > 3) ? 3 : ((STAGES < 0) ? 0 : STAGES);
  localparam logic [1:0] C_W = 2'b10;    // X^2 = W + X
  localparam logic [3:0] C_S = 4'b1000;  // Y^2 = W*X + Y

  function automatic logic [1:0] f4_mul(input logic [1:0] x, input logic [1:0] y);
    return {(x[1] & y[0]) ^ (x[0] & y[1]) ^ (x[1] & y[1]),
            (x[0] & y[0]) ^ (x[1] & y[1])};
  endfunction

  function automatic logic [1:0] f4_inv(input logic [1:0] x);
    return {x[1], x[0] ^ x[1]};
  endfunction

  function automatic logic [3:0] f16_mul(input logic [3:0] x, input logic [3:0] y);
    logic [1:0] hh;
    hh = f4_mul(x[3:2], y[3:2]);
    return {f4_mul(x[1:0], y[3:2]) ^ f4_mul(x[3:2], y[1:0]) ^ hh,
            f4_mul(x[1:0], y[1:0]) ^ f4_mul(hh, C_W)};
  endfunction

  function automatic logic [3:0] f16_inv(input logic [3:0] x);
    logic [1:0] nrm, ni;
    nrm = f4_mul(x[1:0], x[1:0]) ^ f4_mul(x[1:0], x[3:2]) ^
          f4_mul(f4_mul(x[3:2], x[3:2]), C_W);
    ni  = f4_inv(nrm);
    return {f4_mul(ni, x[3:2]), f4_mul(ni, x[1:0] ^ x[3:2])};
  endfunction

  function automatic logic [7:0] f256_mul(input logic [7:0] x, input logic [7:0] y);
    logic [3:0] hh;
    hh = f16_mul(x[7:4], y[7:4]);
    return {f16_mul(x[3:0], y[7:4]) ^ f16_mul(x[7:4], y[3:0]) ^ hh,
            f16_mul(x[3:0], y[3:0]) ^ f16_mul(hh, C_S)};
  endfunction

  function automatic logic [7:0] lin_map(input logic [63:0] m, input logic [7:0] x);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) if (x[i]) r ^= m[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [63:0] find_fwd();
    logic [63:0] m;
    logic [7:0] g, g2, g3, g4, g8, pw;
    logic found;
    m = '0;
    found = 1'b0;
    for (int k = 2; k < 256; k++) begin
      g  = k[7:0];
      g2 = f256_mul(g, g);
      g3 = f256_mul(g2, g);
      g4 = f256_mul(g2, g2);
      g8 = f256_mul(g4, g4);
      if (!found && ((g8 ^ g4 ^ g3 ^ g ^ 8'h01) == 8'h00)) begin
        found = 1'b1;
        pw = 8'h01;
        for (int i = 0; i < 8; i++) begin
          m[i*8 +: 8] = pw;
          pw = f256_mul(pw, g);
        end
      end
    end
    return m;
  endfunction

  function automatic logic [63:0] find_bwd(input logic [63:0] fm);
    logic [63:0] m;
    m = '0;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 256; k++)
        if (lin_map(fm, k[7:0]) == (8'h01 << j)) m[j*8 +: 8] = k[7:0];
    return m;
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^
           {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  localparam logic [63:0] FWD = find_fwd();
  localparam logic [63:0] BWD = find_bwd(FWD);

  // level 0: basis change and 4-bit norm
  logic [7:0] t0;
  logic [3:0] n0;
  assign t0 = lin_map(FWD, din);
  assign n0 = f16_mul(t0[3:0], t0[3:0]) ^ f16_mul(t0[3:0], t0[7:4]) ^
              f16_mul(f16_mul(t0[7:4], t0[7:4]), C_S);

  logic       v1;
  logic [7:0] t1;
  logic [3:0] n1;
  generate
    if (NS > 0) begin : g_cut0
      always_ff @(posedge clk) begin
        v1 <= rst ? 1'b0 : din_vld;
        t1 <= t0;
        n1 <= n0;
      end
    end else begin : g_pass0
      assign v1 = din_vld;
      assign t1 = t0;
      assign n1 = n0;
    end
  endgenerate

  // level 1: 4-bit inversion of the norm
  logic [3:0] ni1;
  assign ni1 = f16_inv(n1);

  logic       v2;
  logic [7:0] t2;
  logic [3:0] ni2;
  generate
    if (NS > 1) begin : g_cut1
      always_ff @(posedge clk) begin
        v2  <= rst ? 1'b0 : v1;
        t2  <= t1;
        ni2 <= ni1;
      end
    end else begin : g_pass1
      assign v2  = v1;
      assign t2  = t1;
      assign ni2 = ni1;
    end
  endgenerate

  // level 2: inverse, back-map, affine
  logic [7:0] inv2, sb2;
  assign inv2 = {f16_mul(ni2, t2[7:4]), f16_mul(ni2, t2[3:0] ^ t2[7:4])};
  assign sb2  = affine(lin_map(BWD, inv2));

  generate
    if (NS > 2) begin : g_cut2
      always_ff @(posedge clk) begin
        dout_vld <= rst ? 1'b0 : v2;
        dout     <= sb2;
      end
    end else begin : g_pass2
      assign dout_vld = v2;
      assign dout     = sb2;
    end
  endgenerate

  AST_MAP_ROUNDTRIP: assert property (@(posedge clk) disable iff (rst)
    din_vld |-> (lin_map(BWD, lin_map(FWD, din)) == din));  // R2
  AST_INV_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    (v2 && t2 != 8'h00) |-> (f256_mul(t2, inv2) == 8'h01));  // R3
  AST_ZERO_INV: assert property (@(posedge clk) disable iff (rst)
    (v2 && t2 == 8'h00) |-> (inv2 == 8'h00));  // R4
  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> !$isunknown(dout));  // R6

  generate
    if (NS > 0) begin : g_lat_chk
      logic [1:0] since_rst;
      always_ff @(posedge clk)
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'(NS)) |-> (dout_vld == $past(din_vld, NS)));  // R5
      AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> !dout_vld);  // R7
    end
  endgenerate
endmodule

// File: tb/sim_aes_sbox_tower.sv
module sim_aes_sbox_tower;
  localparam int LAT = 3;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din_vld = 1'b0;
  logic [7:0] din = 8'h00;
  logic vld_a, vld_b;
  logic [7:0] out_a, out_b;
  int n_run = 0, n_fail = 0;
  logic [7:0] ref_tab [256];
  logic [8:0] expq [$];

  always #4 clk = ~clk;

  aes_sbox_tower #(.STAGES(LAT)) u0 (.clk(clk), .rst(rst), .din_vld(din_vld),
    .din(din), .dout_vld(vld_a), .dout(out_a));
  aes_sbox_tower #(.STAGES(0)) u1 (.clk(clk), .rst(rst), .din_vld(din_vld),
    .din(din), .dout_vld(vld_b), .dout(out_b));

  function automatic logic [7:0] pmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= a;
      a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // one cycle: compare the piped instance, drive, compare the combinational one
  task automatic cyc(input logic v, input logic [7:0] d);
    logic [8:0] e;
    @(negedge clk);
    e = expq.pop_front();
    chk("R5 valid delay", {7'd0, vld_a}, {7'd0, e[8]});
    if (e[8]) chk((e[7:0] == 8'h63) ? "R4/R1 data" : "R1/R6 data", out_a, e[7:0]);
    din_vld = v;
    din = d;
    expq.push_back({v, ref_tab[d]});
    #1;
    chk("R5 zero-stage valid", {7'd0, vld_b}, {7'd0, v});
    if (v) chk("R1 zero-stage data", out_b, ref_tab[d]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din_vld = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 valid in reset", {7'd0, vld_a}, 8'h00);
    rst = 1'b0;
    expq.delete();
    for (int i = 0; i < LAT; i++) expq.push_back(9'h000);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv = 8'h00, s;
      for (int y = 1; y < 256; y++) if (pmul(x[7:0], y[7:0]) == 8'h01) iv = y[7:0];
      for (int i = 0; i < 8; i++)
        s[i] = iv[i] ^ iv[(i+4)%8] ^ iv[(i+5)%8] ^ iv[(i+6)%8] ^ iv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      ref_tab[x] = s;
    end
    chk("R1 table 0x53", ref_tab[8'h53], 8'hED);
    chk("R4 table 0x00", ref_tab[8'h00], 8'h63);
    do_reset();
    cyc(1'b1, 8'h53);  // R1
    cyc(1'b1, 8'h00);  // R4
    cyc(1'b1, 8'h01);  // R1
    cyc(1'b1, 8'hFF);  // R1
    cyc(1'b0, 8'hAA);
    // back-to-back full sweep, exercises R2 and R3 on every element (R6)
    for (int x = 0; x < 256; x++) cyc(1'b1, x[7:0]);
    // gapped valid pattern (R5)
    for (int x = 0; x < 64; x++) cyc(x[0] ^ x[3], 8'(x * 37 + 11));
    // reset with bytes in flight (R7)
    cyc(1'b1, 8'h10);
    cyc(1'b1, 8'h20);
    do_reset();
    @(negedge clk);
    chk("R7 after reset", {7'd0, vld_a}, 8'h00);
    expq.pop_front();
    din_vld = 1'b0;
    expq.push_back(9'h000);
    for (int x = 0; x < 8; x++) cyc(1'b1, 8'(255 - x * 29));
    for (int x = 0; x < LAT + 1; x++) cyc(1'b0, 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule